// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a high-rate oscillator clock by a programmable 18-bit ratio and hands the phase detector one pulse per divided period. It splits the ratio into a low field A and a high field B. A dual-modulus prescaler counts 65 input cycles per prescaler cycle while a swallow counter, loaded with A, is non-zero, and 64 cycles once that counter reaches zero. A main counter, loaded with B, counts prescaler cycles and ends the period. One period therefore lasts 65·A + 64·(B − A) = 64·B + A input cycles. The prescaler is written as ordinary synchronous logic on the input clock, so the whole divider can be simulated.

A new ratio is captured by a one-cycle load strobe into a pending register and only reaches the counters when the current period ends. A standby input holds all counters in their reload state and keeps the output quiet. A status flag shows when the pending ratio has B smaller than A, a setting under which the period is not defined.

Top module: `pswallow_div`

## Requirements
- R1: While rst_n is low, div_pulse_o and ratio_err_o are 0. Release is delayed by two input-clock edges, and the divider then counts with the reset ratio RST_RATIO (default 4032). The first pulse is seen RST_RATIO + 2 cycles after rst_n rises.
- R2: For a ratio with A = ratio_i[5:0], B = ratio_i[17:6] and B ≥ A, div_pulse_o rises once every 64·B + A input cycles.
- R3: div_pulse_o is high for exactly one input-clock cycle per period.
- R4: Ratio 10000 (B = 156, A = 16) gives a period of exactly 10000 cycles.
- R5: The smallest continuous ratio, 4032 (B = 63, A = 0), and the all-ones ratio (262143 at full width) both give periods equal to the ratio.
- R6: A ratio loaded in the middle of a period does not change that period. It applies from the next period on.
- R7: A ratio loaded in the same cycle in which a period ends governs the period that starts right after it.
- R8: While standby is high, div_pulse_o stays 0 and the counters stay in their reload state. After standby falls, the first pulse comes N cycles later, where N is the pending ratio.
- R9: A ratio loaded while standby is high is used for the first period after standby falls.
- R10: One cycle after a load, ratio_err_o is 1 when the loaded B is less than the loaded A, and 0 otherwise. Without a load it keeps its value.
- R11: Pulling rst_n low at any time clears the output at once and restores RST_RATIO as the pending ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Holds the counters cleared and the output low |
| load_i | input | 1 | One-cycle strobe that captures ratio_i |
| ratio_i | input | SW_W+MN_W | Ratio: low SW_W bits are A, upper MN_W bits are B |
| div_pulse_o | output | 1 | One-cycle pulse per divided period |
| ratio_err_o | output | 1 | Pending ratio has B smaller than A |

## Verification
Two events can fall in the same cycle: the reload at the end of a period and the capture of a new ratio. The bench provokes this by raising the load strobe exactly at the cycle where the period ends. It checks that the period just ending keeps the old length and the next period already uses the new ratio, and it contrasts this with a load placed in the middle of a period. The same overlap is provoked between standby and load, with the load made during standby. Every cycle is also compared against a behavioural period counter.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  typedef enum logic {
    MOD_BASE = 1'b0,
    MOD_PLUS = 1'b1
  } psd_mod_e;
endpackage

// File: rtl/psd_prescaler.sv
`timescale 1ns/1ps
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int SW_W = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  psd_mod_e mode,
  output logic     tick
);
  localparam int P    = 1 << SW_W;
  localparam int PC_W = SW_W + 1;

  logic [PC_W-1:0] pc_q, pc_d, pc_last;

  // last state of a prescaler cycle: P (65-cycle mode) or P-1 (64-cycle mode)
  always_comb begin
    pc_last = (mode == MOD_PLUS) ? PC_W'(P) : PC_W'(P - 1);
    tick    = (pc_q == pc_last);
    if (clr || tick) pc_d = '0;
    else             pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/psd_swallow_ctr.sv
`timescale 1ns/1ps
module psd_swallow_ctr
  import psd_pkg::*;
#(
  parameter int SW_W = 6,
  parameter logic [SW_W-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [SW_W-1:0] ld_val,
  input  logic            tick,
  output psd_mod_e        mode,
  output logic [SW_W-1:0] cnt
);
  logic [SW_W-1:0] a_q, a_d;
  logic            a_en;

  always_comb begin
    a_en = reload | (tick & (|a_q));
    a_d  = reload ? ld_val : (a_q - SW_W'(1));
    mode = (|a_q) ? MOD_PLUS : MOD_BASE;
    cnt  = a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    a_q <= RST_VAL;
    else if (a_en) a_q <= a_d;
  end
endmodule

// File: rtl/psd_main_ctr.sv
`timescale 1ns/1ps
module psd_main_ctr #(
  parameter int MN_W = 12,
  parameter logic [MN_W-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [MN_W-1:0] ld_val,
  input  logic            tick,
  output logic            term
);
  logic [MN_W-1:0] b_q, b_d;
  logic            b_en;

  always_comb begin
    b_en = reload | tick;
    b_d  = reload ? ld_val : (b_q - MN_W'(1));
    term = tick & (b_q == MN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    b_q <= RST_VAL;
    else if (b_en) b_q <= b_d;
  end
endmodule

// File: rtl/psd_ratio_reg.sv
`timescale 1ns/1ps
module psd_ratio_reg #(
  parameter int SW_W = 6,
  parameter int MN_W = 12,
  parameter int RW   = SW_W + MN_W,
  parameter logic [RW-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [RW-1:0]   ratio,
  output logic [SW_W-1:0] a_nxt,
  output logic [MN_W-1:0] b_nxt,
  output logic            err
);
  logic [RW-1:0] pend_q, nxt;
  logic          err_q, err_d;

  always_comb begin
    // a strobe in the boundary cycle bypasses the pending register
    nxt   = load ? ratio : pend_q;
    a_nxt = nxt[SW_W-1:0];
    b_nxt = nxt[RW-1:SW_W];
    err_d = (ratio[RW-1:SW_W] < MN_W'(ratio[SW_W-1:0]));
    err   = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_VAL;
      err_q  <= (RST_VAL[RW-1:SW_W] < MN_W'(RST_VAL[SW_W-1:0]));
    end else if (load) begin
      pend_q <= ratio;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/pswallow_div.sv
`timescale 1ns/1ps
module pswallow_div
  import psd_pkg::*;
#(
  parameter int          SW_W      = 6,
  parameter int          MN_W      = 12,
  parameter int unsigned RST_RATIO = 4032
) (
  input  logic                 clk_in,
  input  logic                 rst_n,
  input  logic                 standby,
  input  logic                 load_i,
  input  logic [SW_W+MN_W-1:0] ratio_i,
  output logic                 div_pulse_o,
  output logic                 ratio_err_o
);
  localparam int RW = SW_W + MN_W;
  localparam logic [RW-1:0] RST_R = RW'(RST_RATIO);

  logic            rs1_q, rs2_q, rst_sync_n;
  logic            tick, b_term, period_end, reload;
  logic            pulse_q, pulse_d;
  logic [SW_W-1:0] a_nxt, a_cnt;
  logic [MN_W-1:0] b_nxt;
  psd_mod_e        mode;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  psd_ratio_reg #(.SW_W(SW_W), .MN_W(MN_W), .RW(RW), .RST_VAL(RST_R)) u_ratio (
    .clk(clk_in), .rst_n(rst_sync_n), .load(load_i), .ratio(ratio_i),
    .a_nxt(a_nxt), .b_nxt(b_nxt), .err(ratio_err_o)
  );

  psd_prescaler #(.SW_W(SW_W)) u_pre (
    .clk(clk_in), .rst_n(rst_sync_n), .clr(reload), .mode(mode), .tick(tick)
  );

  psd_swallow_ctr #(.SW_W(SW_W), .RST_VAL(RST_R[SW_W-1:0])) u_swl (
    .clk(clk_in), .rst_n(rst_sync_n), .reload(reload), .ld_val(a_nxt),
    .tick(tick), .mode(mode), .cnt(a_cnt)
  );

  psd_main_ctr #(.MN_W(MN_W), .RST_VAL(RST_R[RW-1:SW_W])) u_main (
    .clk(clk_in), .rst_n(rst_sync_n), .reload(reload), .ld_val(b_nxt),
    .tick(tick), .term(b_term)
  );

  always_comb begin
    period_end = b_term;
    reload     = standby | period_end;
    pulse_d    = period_end & ~standby;
  end

  always_ff @(posedge clk_in or negedge rst_sync_n) begin
    if (!rst_sync_n) pulse_q <= 1'b0;
    else             pulse_q <= pulse_d;
  end
  assign div_pulse_o = pulse_q;
endmodule

// File: rtl/psd_div_chk.sv
`timescale 1ns/1ps
module psd_div_chk #(
  parameter int SW_W = 6,
  parameter int MN_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 standby,
  input logic                 load,
  input logic [SW_W+MN_W-1:0] ratio,
  input logic                 pulse,
  input logic                 err,
  input logic [SW_W-1:0]      a_cnt,
  input logic                 period_end
);
  localparam int RW = SW_W + MN_W;

  logic ld_bad;
  assign ld_bad = (ratio[RW-1:SW_W] < MN_W'(ratio[SW_W-1:0]));

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R8
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !pulse);

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ld_bad) |=> err);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ld_bad) |=> !err);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(err));

  // R2
  swallow_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && !period_end) |=> (a_cnt <= $past(a_cnt)));
endmodule

bind pswallow_div psd_div_chk #(.SW_W(SW_W), .MN_W(MN_W)) u_chk (
  .clk(clk_in), .rst_n(rst_sync_n), .standby(standby), .load(load_i),
  .ratio(ratio_i), .pulse(div_pulse_o), .err(ratio_err_o),
  .a_cnt(a_cnt), .period_end(period_end)
);

// File: tb/test_pswallow_div.sv
`timescale 1ns/1ps
module test_pswallow_div;
  localparam int SW_W = 6;
  localparam int MN_W = 10;
  localparam int RW   = SW_W + MN_W;
  localparam int P    = 1 << SW_W;
  localparam int RSTR = 4032;
  localparam int MAXR = (1 << RW) - 1;

  logic          clk_in = 1'b0;
  logic          rst_n = 1'b0;
  logic          standby = 1'b0;
  logic          load_i = 1'b0;
  logic [RW-1:0] ratio_i = '0;
  logic          div_pulse_o, ratio_err_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    run_cmp = 1'b0;
  string cur_req = "R1";

  always #2.5 clk_in = ~clk_in;

  pswallow_div #(.SW_W(SW_W), .MN_W(MN_W), .RST_RATIO(RSTR)) i_pswallow_div (
    .clk_in(clk_in), .rst_n(rst_n), .standby(standby), .load_i(load_i),
    .ratio_i(ratio_i), .div_pulse_o(div_pulse_o), .ratio_err_o(ratio_err_o)
  );

  function automatic bit is_bad(int r);
    return (r / P) < (r % P);
  endfunction

  // behavioural reference: a plain period counter
  int m_pend = RSTR, m_n = RSTR, m_cnt = 0;
  bit m_pulse = 0, m_err = 0, m_s1 = 0, m_s2 = 0;

  always @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pend = RSTR; m_n = RSTR; m_cnt = 0;
      m_pulse = 0; m_err = is_bad(RSTR);
    end else begin
      if (m_s2) begin
        if (standby) begin
          m_cnt = 0; m_pulse = 0;
          m_n = load_i ? int'(ratio_i) : m_pend;
        end else begin
          m_cnt++;
          if (m_cnt == m_n) begin
            m_pulse = 1; m_cnt = 0;
            m_n = load_i ? int'(ratio_i) : m_pend;
          end else m_pulse = 0;
        end
        if (load_i) begin
          m_pend = int'(ratio_i);
          m_err  = is_bad(int'(ratio_i));
        end
      end
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk_in) begin
    if (run_cmp) begin
      chk(div_pulse_o == m_pulse, cur_req, "pulse vs model", int'(div_pulse_o), int'(m_pulse));
      chk(ratio_err_o == m_err, cur_req, "flag vs model", int'(ratio_err_o), int'(m_err));
    end
  end

  // counts negedges until a pulse; optional load strobe at count ld_at
  task automatic measure(int exp, string req, int ld_at, int ld_val);
    int cnt = 0;
    cur_req = req;
    do begin
      @(negedge clk_in);
      cnt++;
      if (cnt == ld_at) begin
        load_i = 1'b1; ratio_i = RW'(ld_val);
      end else load_i = 1'b0;
    end while (!div_pulse_o && cnt < 300000);
    load_i = 1'b0;
    chk(cnt == exp, req, "period", cnt, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_in);
  endtask

  initial begin
    repeat (200000) @(posedge clk_in);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    run_cmp = 1'b1;
    // R1: reset state
    chk(div_pulse_o == 1'b0, "R1", "pulse in reset", int'(div_pulse_o), 0);
    chk(ratio_err_o == 1'b0, "R1", "flag in reset", int'(ratio_err_o), 0);
    rst_n = 1'b1;
    measure(RSTR + 2, "R1", -1, 0);
    // R5 minimum ratio; R6 mid-period load keeps this period
    measure(RSTR, "R5", -1, 0);
    measure(RSTR, "R6", 100, 10000);
    // R4: 10000 = 64*156 + 16; R7: load in the boundary cycle
    measure(10000, "R4", 9999, 4100);
    measure(4100, "R7", 4099, MAXR);
    // R5: all-ones ratio
    measure(MAXR, "R5", -1, 0);
    // R8/R9: standby mid-period with a load during it
    idle(300);
    cur_req = "R8";
    standby = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_in);
      chk(div_pulse_o == 1'b0, "R8", "pulse in standby", int'(div_pulse_o), 0);
      if (i == 5) begin load_i = 1'b1; ratio_i = RW'(RSTR); end
      else load_i = 1'b0;
    end
    standby = 1'b0;
    measure(RSTR, "R9", -1, 0);
    measure(RSTR, "R2", -1, 0);
    // R10: flag for B=2, A=10 (ratio 138), then cleared by a legal load
    standby = 1'b1;
    @(negedge clk_in);
    load_i = 1'b1; ratio_i = RW'(138);
    cur_req = "R10";
    @(negedge clk_in);
    load_i = 1'b0;
    chk(ratio_err_o == 1'b1, "R10", "flag after B<A load", int'(ratio_err_o), 1);
    idle(10);
    chk(ratio_err_o == 1'b1, "R10", "flag held", int'(ratio_err_o), 1);
    load_i = 1'b1; ratio_i = RW'(10000);
    @(negedge clk_in);
    load_i = 1'b0;
    chk(ratio_err_o == 1'b0, "R10", "flag after legal load", int'(ratio_err_o), 0);
    standby = 1'b0;
    measure(10000, "R8", -1, 0);
    // R11: asynchronous reset in mid-period restores the reset ratio
    idle(50);
    #1 rst_n = 1'b0;
    #0.5;
    chk(div_pulse_o == 1'b0, "R11", "pulse on async reset", int'(div_pulse_o), 0);
    @(negedge clk_in);
    rst_n = 1'b1;
    measure(RSTR + 2, "R11", -1, 0);
    // R3: pulse gone one cycle later
    @(negedge clk_in);
    chk(div_pulse_o == 1'b0, "R3", "pulse width", int'(div_pulse_o), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule